// File: doc/BRIEF.md
# External Bus Access-State Sequencer

This block turns a single read or write request into an external memory access cycle. The top three address bits select one of eight areas. Each area has its own settings: a data width of 8 or 16 bits, an access length of two or three bus states, and a count of zero to three wait states. An accepted request is sequenced through its states, and the address strobe and the read or write strobe are driven for it. When the access is complete, a one-cycle done pulse is raised. A 16-bit request to an 8-bit area is carried out as two byte cycles, one after the other.

The block also reports the global bus mode from the area settings. Area settings are loaded through a small write port, one area at a time. The reset width of every area comes from a mode pin. A boot-area burst-select input forces 16-bit mode, whatever the area widths are.

Top module: `ext_bus_seq`

## Requirements
- R1: The area is taken from address bits [23:21]. The access length and the width handling come from that area's settings, as they stood when the request was accepted.
- R2: An access to a 2-state area lasts exactly 2 cycles per byte cycle, whatever its wait field holds.
- R3: An access to a 3-state area lasts 3 + w cycles per byte cycle, where w (0 to 3) is the area's 2-bit wait field.
- R4: After reset, every area is 3-state with wait field 3, and its width is 16-bit when mode_wide was 1 during reset and 8-bit otherwise. No access is in progress and all strobes are high.
- R5: bus_mode16 is 1 when any area is 16-bit or boot_burst is 1. It is 0 only when every area is 8-bit and boot_burst is 0.
- R6: In the first cycle of each byte cycle, only ext_as_n is low. The read or write strobe (ext_rd_n when req_we=0, ext_wr_n when req_we=1) is low from the second cycle to the last cycle of the byte cycle. done is high for exactly one cycle, on the last cycle of the access.
- R7: A 16-bit request (req_size16=1) to an 8-bit area runs two byte cycles. The first uses the even address (bit 0 = 0) and carries the upper byte. The second uses the odd address and carries the lower byte. Both travel on lane [7:0]. done follows the second byte cycle only, and rdata = {first byte, second byte}.
- R8: A 16-bit request to a 16-bit area runs one cycle on both lanes. A byte request (req_size16=0) runs one cycle on lane [7:0], and the upper half of rdata reads 0.
- R9: A request is accepted only while busy is low. A request raised during an access starts no access, and busy falls in the cycle after done.
- R10: A settings write (cfg_we) updates the addressed area. A write on the same clock edge that accepts a request does not change that access; it applies from the next request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_wide | input | 1 | Reset width of all areas (1 = 16-bit) |
| boot_burst | input | 1 | Boot-area burst select, forces 16-bit bus mode |
| cfg_we | input | 1 | Settings write strobe |
| cfg_area | input | 3 | Area written |
| cfg_wide | input | 1 | New width (1 = 16-bit) |
| cfg_three | input | 1 | New state count (1 = 3-state, 0 = 2-state) |
| cfg_waits | input | 2 | New wait-state count |
| req | input | 1 | Access request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_size16 | input | 1 | 1 = 16-bit transfer, 0 = byte |
| req_addr | input | 24 | Request address |
| req_wdata | input | 16 | Write data |
| busy | output | 1 | Access in progress |
| done | output | 1 | Last cycle of the access |
| rdata | output | 16 | Read result, valid while done is high |
| ext_addr | output | 24 | External address |
| ext_as_n | output | 1 | Address strobe, active low |
| ext_rd_n | output | 1 | Read strobe, active low |
| ext_wr_n | output | 1 | Write strobe, active low |
| ext_dout | output | 16 | External write data |
| ext_din | input | 16 | External read data |
| bus_mode16 | output | 1 | Global bus mode (1 = 16-bit) |

## Verification
A settings write and the acceptance of a request can fall on the same clock edge. The bench provokes this by raising cfg_we and req at the same falling edge. The write changes the wait count of the very area being accessed. The bench then judges that this access still runs at the old length and that the next one runs at the new length. The end of an access can also coincide with a pending request. The bench holds req high while an access runs, and checks that exactly one done pulse appears and that busy drops after it.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

    parameter int XB_WAIT_W = 2;

    typedef struct packed {
        logic                 wide;
        logic                 three;
        logic [XB_WAIT_W-1:0] waits;
    } area_cfg_t;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_T1   = 3'd1,
        PH_T2   = 3'd2,
        PH_TW   = 3'd3,
        PH_T3   = 3'd4
    } phase_e;

endpackage

// File: rtl/xbus_area_cfg.sv
module xbus_area_cfg
    import xbus_pkg::*;
#(
    parameter int AREA_BITS = 3
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             mode_wide,
    input  logic                             boot_burst,
    input  logic                             cfg_we,
    input  logic [AREA_BITS-1:0]             cfg_area,
    input  area_cfg_t                        cfg_new,
    output area_cfg_t [(1<<AREA_BITS)-1:0]   cfg_table,
    output logic                             bus_mode16
);
    localparam int NUM_AREAS = 1 << AREA_BITS;

    area_cfg_t cfg_d [NUM_AREAS];
    area_cfg_t cfg_q [NUM_AREAS];

    for (genvar g = 0; g < NUM_AREAS; g++) begin : g_area
        localparam logic [AREA_BITS-1:0] IDX = AREA_BITS'(g);

        always_comb begin
            cfg_d[g] = cfg_q[g];
            if (cfg_we && (cfg_area == IDX)) begin
                cfg_d[g] = cfg_new;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cfg_q[g].wide  <= mode_wide;
                cfg_q[g].three <= 1'b1;
                cfg_q[g].waits <= '1;
            end else begin
                cfg_q[g] <= cfg_d[g];
            end
        end
    end

    always_comb begin
        logic any_wide;
        any_wide = 1'b0;
        for (int i = 0; i < NUM_AREAS; i++) begin
            cfg_table[i] = cfg_q[i];
            any_wide     = any_wide | cfg_q[i].wide;
        end
        bus_mode16 = any_wide | boot_burst;
    end

endmodule

// File: rtl/xbus_seq_fsm.sv
module xbus_seq_fsm
    import xbus_pkg::*;
#(
    parameter int ADDR_W    = 24,
    parameter int AREA_BITS = 3,
    parameter int DATA_W    = 16
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            req,
    input  logic                            req_we,
    input  logic                            req_size16,
    input  logic [ADDR_W-1:0]               req_addr,
    input  logic [DATA_W-1:0]               req_wdata,
    input  area_cfg_t [(1<<AREA_BITS)-1:0]  cfg_table,
    input  logic [DATA_W/2-1:0]             din_lo,
    output logic                            busy,
    output logic                            done,
    output logic                            strobe,
    output logic                            acc_we,
    output logic                            acc_size16,
    output logic                            acc_split,
    output logic                            acc_second,
    output logic [ADDR_W-1:0]               bus_addr,
    output logic [DATA_W-1:0]               acc_wdata,
    output logic [DATA_W/2-1:0]             acc_hi
);
    localparam int BYTE_W = DATA_W / 2;

    typedef struct packed {
        phase_e               ph;
        logic [XB_WAIT_W-1:0] wcnt;
        logic                 second;
        logic                 split;
        logic                 we;
        logic                 size16;
        logic [ADDR_W-1:0]    addr;
        logic [DATA_W-1:0]    wdata;
        logic [BYTE_W-1:0]    hi;
        area_cfg_t            cfg;
    } seq_t;

    localparam seq_t SEQ_RST = '0;

    seq_t s_d, s_q;
    logic beat_end;
    area_cfg_t sel_cfg;

    always_comb begin
        sel_cfg  = cfg_table[req_addr[ADDR_W-1 -: AREA_BITS]];
        beat_end = ((s_q.ph == PH_T2) && !s_q.cfg.three) || (s_q.ph == PH_T3);
        s_d      = s_q;

        case (s_q.ph)
            PH_IDLE: begin
                if (req) begin
                    s_d.ph     = PH_T1;
                    s_d.addr   = req_addr;
                    s_d.we     = req_we;
                    s_d.size16 = req_size16;
                    s_d.wdata  = req_wdata;
                    s_d.cfg    = sel_cfg;
                    s_d.split  = req_size16 && !sel_cfg.wide;
                    s_d.second = 1'b0;
                    s_d.wcnt   = '0;
                end
            end
            PH_T1: s_d.ph = PH_T2;
            PH_T2: begin
                if (s_q.cfg.three) begin
                    if (s_q.cfg.waits != '0) begin
                        s_d.ph   = PH_TW;
                        s_d.wcnt = s_q.cfg.waits - XB_WAIT_W'(1);
                    end else begin
                        s_d.ph = PH_T3;
                    end
                end
            end
            PH_TW: begin
                if (s_q.wcnt == '0) begin
                    s_d.ph = PH_T3;
                end else begin
                    s_d.wcnt = s_q.wcnt - XB_WAIT_W'(1);
                end
            end
            default: ;
        endcase

        if (beat_end) begin
            if (s_q.split && !s_q.second) begin
                s_d.second = 1'b1;
                s_d.ph     = PH_T1;
                s_d.hi     = din_lo;
            end else begin
                s_d.ph = PH_IDLE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= SEQ_RST;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        busy       = (s_q.ph != PH_IDLE);
        done       = beat_end && (!s_q.split || s_q.second);
        strobe     = busy && (s_q.ph != PH_T1);
        acc_we     = s_q.we;
        acc_size16 = s_q.size16;
        acc_split  = s_q.split;
        acc_second = s_q.second;
        acc_wdata  = s_q.wdata;
        acc_hi     = s_q.hi;
        bus_addr   = s_q.addr;
        if (s_q.split) begin
            bus_addr[0] = s_q.second;
        end
    end

endmodule

// File: rtl/xbus_lane.sv
module xbus_lane #(
    parameter int DATA_W = 16
) (
    input  logic                split,
    input  logic                second,
    input  logic                size16,
    input  logic [DATA_W-1:0]   wdata,
    input  logic [DATA_W/2-1:0] hi,
    input  logic [DATA_W-1:0]   din,
    output logic [DATA_W-1:0]   dout,
    output logic [DATA_W-1:0]   rdata
);
    localparam int BYTE_W = DATA_W / 2;

    always_comb begin
        if (split) begin
            dout  = {{BYTE_W{1'b0}}, (second ? wdata[BYTE_W-1:0] : wdata[DATA_W-1:BYTE_W])};
            rdata = {hi, din[BYTE_W-1:0]};
        end else if (size16) begin
            dout  = wdata;
            rdata = din;
        end else begin
            dout  = {{BYTE_W{1'b0}}, wdata[BYTE_W-1:0]};
            rdata = {{BYTE_W{1'b0}}, din[BYTE_W-1:0]};
        end
    end

endmodule

// File: rtl/ext_bus_seq.sv
module ext_bus_seq
    import xbus_pkg::*;
#(
    parameter int ADDR_W    = 24,
    parameter int AREA_BITS = 3,
    parameter int DATA_W    = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 mode_wide,
    input  logic                 boot_burst,
    input  logic                 cfg_we,
    input  logic [AREA_BITS-1:0] cfg_area,
    input  logic                 cfg_wide,
    input  logic                 cfg_three,
    input  logic [XB_WAIT_W-1:0] cfg_waits,
    input  logic                 req,
    input  logic                 req_we,
    input  logic                 req_size16,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [DATA_W-1:0]    req_wdata,
    output logic                 busy,
    output logic                 done,
    output logic [DATA_W-1:0]    rdata,
    output logic [ADDR_W-1:0]    ext_addr,
    output logic                 ext_as_n,
    output logic                 ext_rd_n,
    output logic                 ext_wr_n,
    output logic [DATA_W-1:0]    ext_dout,
    input  logic [DATA_W-1:0]    ext_din,
    output logic                 bus_mode16
);
    localparam int NUM_AREAS = 1 << AREA_BITS;
    localparam int BYTE_W    = DATA_W / 2;

    area_cfg_t                 cfg_new;
    area_cfg_t [NUM_AREAS-1:0] cfg_table;
    logic                      strobe, acc_we, acc_size16, acc_split, acc_second;
    logic [DATA_W-1:0]         acc_wdata;
    logic [BYTE_W-1:0]         acc_hi;

    always_comb begin
        cfg_new.wide  = cfg_wide;
        cfg_new.three = cfg_three;
        cfg_new.waits = cfg_waits;
    end

    xbus_area_cfg #(.AREA_BITS(AREA_BITS)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_wide  (mode_wide),
        .boot_burst (boot_burst),
        .cfg_we     (cfg_we),
        .cfg_area   (cfg_area),
        .cfg_new    (cfg_new),
        .cfg_table  (cfg_table),
        .bus_mode16 (bus_mode16)
    );

    xbus_seq_fsm #(.ADDR_W(ADDR_W), .AREA_BITS(AREA_BITS), .DATA_W(DATA_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (req),
        .req_we     (req_we),
        .req_size16 (req_size16),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .cfg_table  (cfg_table),
        .din_lo     (ext_din[BYTE_W-1:0]),
        .busy       (busy),
        .done       (done),
        .strobe     (strobe),
        .acc_we     (acc_we),
        .acc_size16 (acc_size16),
        .acc_split  (acc_split),
        .acc_second (acc_second),
        .bus_addr   (ext_addr),
        .acc_wdata  (acc_wdata),
        .acc_hi     (acc_hi)
    );

    xbus_lane #(.DATA_W(DATA_W)) u_lane (
        .split  (acc_split),
        .second (acc_second),
        .size16 (acc_size16),
        .wdata  (acc_wdata),
        .hi     (acc_hi),
        .din    (ext_din),
        .dout   (ext_dout),
        .rdata  (rdata)
    );

    always_comb begin
        ext_as_n = !busy;
        ext_rd_n = !(strobe && !acc_we);
        ext_wr_n = !(strobe && acc_we);
    end

endmodule

// File: rtl/xbus_seq_chk.sv
module xbus_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic req,
    input logic busy,
    input logic done,
    input logic ext_as_n,
    input logic ext_rd_n,
    input logic ext_wr_n
);
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R6
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(!ext_rd_n && !ext_wr_n)); // R6
    AST_STROBE_INSIDE: assert property (@(posedge clk) disable iff (!rst_n) (!ext_rd_n || !ext_wr_n) |-> !ext_as_n); // R6
    AST_FIRST_STATE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (req && !busy) |=> (busy && !ext_as_n && ext_rd_n && ext_wr_n)); // R6
    AST_IDLE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !busy); // R9
    AST_HOLD_UNTIL_DONE: assert property (@(posedge clk) disable iff (!rst_n) (busy && !done) |=> busy); // R9
endmodule

bind ext_bus_seq xbus_seq_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (req),
    .busy     (busy),
    .done     (done),
    .ext_as_n (ext_as_n),
    .ext_rd_n (ext_rd_n),
    .ext_wr_n (ext_wr_n)
);

// File: tb/tb_ext_bus_seq.sv
`timescale 1ns/1ps
module tb_ext_bus_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_wide = 1'b0, boot_burst = 1'b0;
    logic        cfg_we = 1'b0, cfg_wide = 1'b0, cfg_three = 1'b0;
    logic [2:0]  cfg_area = '0;
    logic [1:0]  cfg_waits = '0;
    logic        req = 1'b0, req_we = 1'b0, req_size16 = 1'b0;
    logic [23:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        busy, done, ext_as_n, ext_rd_n, ext_wr_n, bus_mode16;
    logic [15:0] rdata, ext_dout, ext_din;
    logic [23:0] ext_addr;

    always #2.5 clk = ~clk;

    ext_bus_seq dut (
        .clk(clk), .rst_n(rst_n), .mode_wide(mode_wide), .boot_burst(boot_burst),
        .cfg_we(cfg_we), .cfg_area(cfg_area), .cfg_wide(cfg_wide), .cfg_three(cfg_three),
        .cfg_waits(cfg_waits), .req(req), .req_we(req_we), .req_size16(req_size16),
        .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .done(done), .rdata(rdata),
        .ext_addr(ext_addr), .ext_as_n(ext_as_n), .ext_rd_n(ext_rd_n), .ext_wr_n(ext_wr_n),
        .ext_dout(ext_dout), .ext_din(ext_din), .bus_mode16(bus_mode16)
    );

    function automatic logic [15:0] mem(input logic [23:0] a);
        return a[15:0] ^ 16'h5A3C;
    endfunction
    assign ext_din = mem(ext_addr);

    int nchk = 0, nerr = 0, cyc = 0, done_cnt = 0;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // bench model of area settings
    bit       m_wide [8];
    bit       m_three[8];
    bit [1:0] m_wait [8];

    task automatic model_reset(input bit w);
        for (int i = 0; i < 8; i++) begin
            m_wide[i] = w; m_three[i] = 1'b1; m_wait[i] = 2'd3;
        end
    endtask

    typedef struct {
        int          start;
        int          ncyc;
        bit          we;
        logic [15:0] rd;
        int          strobes;
        int          beats;
        logic [23:0] ba[2];
        logic [15:0] bd[2];
        string       tag;
    } exp_t;
    exp_t exp_q[$];

    // monitor
    bit          prev_stb = 0, prev_done = 0;
    int          stb_cnt = 0, nb = 0;
    logic [23:0] m_ba[2];
    logic [15:0] m_bd[2];
    always @(negedge clk) begin
        if (rst_n) begin
            bit stb;
            stb = !ext_rd_n || !ext_wr_n;
            if (stb) stb_cnt++;
            if (stb && !prev_stb) begin
                if (nb < 2) begin m_ba[nb] = ext_addr; m_bd[nb] = ext_dout; end
                nb++;
            end
            prev_stb = stb;
            if (prev_done && done) check(0, "R6 done longer than one cycle", 1, 0);
            if (done) begin
                done_cnt++;
                if (exp_q.size() == 0) begin
                    check(0, "R9 unexpected done", 1, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(cyc == e.start + e.ncyc - 1, {e.tag, " access length"}, cyc - e.start + 1, e.ncyc);
                    if (!e.we) check(rdata == e.rd, {e.tag, " rdata"}, rdata, e.rd);
                    check(stb_cnt == e.strobes, "R6 strobe cycles", stb_cnt, e.strobes);
                    check(nb == e.beats, {e.tag, " byte cycles"}, nb, e.beats);
                    for (int k = 0; k < e.beats && k < 2 && k < nb; k++) begin
                        check(m_ba[k] == e.ba[k], {e.tag, " beat address"}, m_ba[k], e.ba[k]);
                        if (e.we) check(m_bd[k] == e.bd[k], {e.tag, " beat data"}, m_bd[k], e.bd[k]);
                    end
                end
                stb_cnt = 0; nb = 0;
            end
            prev_done = done;
        end else begin
            prev_stb = 0; prev_done = 0; stb_cnt = 0; nb = 0;
        end
    end

    task automatic cfg_write(input int a, input bit w, input bit t, input logic [1:0] ws);
        @(negedge clk);
        cfg_we = 1; cfg_area = 3'(a); cfg_wide = w; cfg_three = t; cfg_waits = ws;
        @(negedge clk);
        cfg_we = 0;
        m_wide[a] = w; m_three[a] = t; m_wait[a] = ws;
    endtask

    // driver: pushes the expected item, optional same-edge settings write, optional extra req
    task automatic access(input bit we, input bit s16, input logic [23:0] a, input logic [15:0] w,
                          input string tag, input int extra, input bit cw, input int ca,
                          input bit cwide, input bit cthree, input logic [1:0] cwait);
        exp_t e;
        int ar, beat;
        bit split;
        ar    = int'(a[23:21]);
        beat  = m_three[ar] ? 3 + int'(m_wait[ar]) : 2;
        split = s16 && !m_wide[ar];
        e.we = we; e.tag = tag;
        e.beats   = split ? 2 : 1;
        e.ncyc    = beat * e.beats;
        e.strobes = (beat - 1) * e.beats;
        if (split) begin
            e.ba[0] = {a[23:1], 1'b0}; e.ba[1] = {a[23:1], 1'b1};
            e.bd[0] = {8'h00, w[15:8]}; e.bd[1] = {8'h00, w[7:0]};
            e.rd    = {mem(e.ba[0])[7:0], mem(e.ba[1])[7:0]};
        end else begin
            e.ba[0] = a; e.ba[1] = a;
            e.bd[0] = s16 ? w : {8'h00, w[7:0]}; e.bd[1] = e.bd[0];
            e.rd    = s16 ? mem(a) : {8'h00, mem(a)[7:0]};
        end
        @(negedge clk);
        req = 1; req_we = we; req_size16 = s16; req_addr = a; req_wdata = w;
        if (cw) begin
            cfg_we = 1; cfg_area = 3'(ca); cfg_wide = cwide; cfg_three = cthree; cfg_waits = cwait;
        end
        @(posedge clk);
        #1;
        e.start = cyc;
        exp_q.push_back(e);
        if (cw) begin m_wide[ca] = cwide; m_three[ca] = cthree; m_wait[ca] = cwait; end
        @(negedge clk);
        req = 0; cfg_we = 0;
        if (extra > 0) begin
            req = 1; req_addr = 24'hE00002; req_we = ~we;
            repeat (extra) @(negedge clk);
            req = 0;
        end
        while (busy) @(negedge clk);
    endtask

    task automatic rd(input bit s16, input logic [23:0] a, input string tag);
        access(0, s16, a, 16'h0, tag, 0, 0, 0, 0, 0, 2'd0);
    endtask

    task automatic do_reset(input bit w);
        @(negedge clk);
        rst_n = 0; mode_wide = w;
        repeat (3) @(negedge clk);
        rst_n = 1;
        model_reset(w);
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        check(0, "watchdog", cyc, 0);
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        int d0;
        do_reset(0);
        // R4 reset state
        check(busy == 0 && done == 0, "R4 idle after reset", {busy, done}, 0);
        check(ext_as_n && ext_rd_n && ext_wr_n, "R4 strobes high", {ext_as_n, ext_rd_n, ext_wr_n}, 7);
        check(bus_mode16 == 0, "R4 width from mode pin", bus_mode16, 0);
        rd(0, 24'h000123, "R4 default 3-state wait 3");
        // R2 two-state ignores wait field, R8 full-width access
        cfg_write(2, 1, 0, 2'd3);
        check(bus_mode16 == 1, "R5 one wide area", bus_mode16, 1);
        rd(1, 24'h400010, "R2 two-state R8 wide read");
        access(1, 1, 24'h400020, 16'hC0DE, "R8 wide write", 0, 0, 0, 0, 0, 2'd0);
        rd(0, 24'h400031, "R8 byte read on wide area");
        // R3 wait counts
        for (int w = 0; w < 4; w++) begin
            cfg_write(3, 0, 1, 2'(w));
            rd(0, 24'h600040 + 24'(w), "R3 wait count");
        end
        // R1 same low address, different areas
        cfg_write(7, 0, 0, 2'd1);
        cfg_write(6, 0, 1, 2'd2);
        rd(0, 24'hE00055, "R1 area 7");
        rd(0, 24'hC00055, "R1 area 6");
        // R7 split read and write
        cfg_write(4, 0, 1, 2'd1);
        rd(1, 24'h800041, "R7 split read");
        access(1, 1, 24'h800046, 16'hBEEF, "R7 split write", 0, 0, 0, 0, 0, 2'd0);
        cfg_write(5, 0, 0, 2'd2);
        rd(1, 24'hA00010, "R7 split on two-state area");
        // R5 bus mode
        cfg_write(2, 0, 0, 2'd3);
        @(negedge clk);
        check(bus_mode16 == 0, "R5 all narrow", bus_mode16, 0);
        boot_burst = 1;
        @(negedge clk);
        check(bus_mode16 == 1, "R5 burst forces wide", bus_mode16, 1);
        boot_burst = 0;
        @(negedge clk);
        check(bus_mode16 == 0, "R5 burst released", bus_mode16, 0);
        // R9 request during access ignored
        d0 = done_cnt;
        access(0, 0, 24'h000077, 16'h0, "R9 busy access", 3, 0, 0, 0, 0, 2'd0);
        repeat (6) @(negedge clk);
        check(done_cnt == d0 + 1, "R9 one done for one accepted request", done_cnt - d0, 1);
        check(busy == 0, "R9 no extra access", busy, 0);
        // R10 settings write on the accepting edge
        access(0, 0, 24'h000099, 16'h0, "R10 old settings kept", 0, 1, 0, 0, 1, 2'd0);
        rd(0, 24'h00009A, "R10 new settings used");
        // R4 reset with wide mode
        do_reset(1);
        check(bus_mode16 == 1, "R4 wide mode pin", bus_mode16, 1);
        rd(1, 24'hA00020, "R4 wide reset single cycle");
        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R6 all accesses completed", exp_q.size(), 0);
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule